// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block turns a synchronous word request stream into the strobe sequences of a 1M x 16 asynchronous DRAM with extended data out. Each request carries a 20-bit word address, a write flag, two byte enables and 16 bits of write data. The address splits into a row half and a column half that share one 10-bit multiplexed address bus. The controller lowers the row strobe, waits the row-to-column delay, presents the column, and then pulses the upper and/or lower column strobe. Read data comes back on a response port with a one-cycle valid pulse.

The row stays open after an access. Later requests to the same row are served as page cycles, in which only the column strobes toggle. The row is closed in four cases: a request misses it, the refresh arbiter asks for the bus, the row strobe has been low for nearly its longest legal time, or both of these last two apply. Every DRAM timing value is a parameter counted in clock cycles.

Back-pressure: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` does not depend on `req_valid`, and it stays low while a column cycle, a precharge or a refresh grant is under way. While `req_ready` is low the request inputs are ignored, and the requester must hold them. The response port has no back-pressure.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row half of the address is `req_addr[19:10]` and the column half is `req_addr[9:0]`. The row is on `dram_addr` when `dram_ras_n` falls. The column is on `dram_addr` when a column strobe falls.
- R2: After the row strobe falls, the first column strobe falls exactly T_RCD+1 cycles later. The column address is driven in the single cycle just before that fall.
- R3: `req_be[0]` selects the lower byte: `dram_lcas_n` and DQ[7:0]. `req_be[1]` selects the upper byte: `dram_ucas_n` and DQ[15:8]. A request with `req_be` = 00 is served as a full-word access.
- R4: For a write, `dram_we_n` is low in the cycle before the column strobe falls and stays low while the strobe is low. During that time `dram_oe_n` is high, and `dram_dq_oe` drives the write data.
- R5: For a read, data is sampled at the end of the column-strobe-low period. That period lasts max(T_CAS, T_CAC, T_AA-1), and on the first access after the row opens it is at least T_RAC-T_RCD-1. The data is returned with `rsp_valid` high for exactly one cycle. Bits of a lane whose enable is clear return as zero.
- R6: A request to the open row is served without raising `dram_ras_n`.
- R7: A request to a different row raises `dram_ras_n` for T_RP cycles and then opens the new row.
- R8: `req_ready` is low whenever a column strobe or the write enable is active. A request held while `req_ready` is low has no effect on the memory.
- R9: While `ref_req` is high, `req_ready` is low. The open row is closed, and `ref_gnt` rises only with `dram_ras_n` high after the T_RP precharge. `ref_gnt` falls after `ref_req` drops.
- R10: Each row-strobe low period lasts at least T_RAS_MIN cycles and fewer than T_RAS_MAX cycles. An idle open row is closed on its own before that limit.
- R11: Each column strobe stays low for at least T_CAS cycles. Between two column cycles it stays high for at least T_CP cycles.
- R12: During and after reset, all strobes are high, the data driver is off, `rsp_valid` and `ref_gnt` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 20 | Word address, row in the upper half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh arbiter wants the DRAM bus |
| ref_gnt | output | 1 | Bus released for refresh |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data to the DRAM |
| dram_dq_oe | output | 1 | Enable for the data driver |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
With the default timings, the read response is due 11 cycles after acceptance from an idle bus (T_RCD+1+6+1). It is due 6 cycles after acceptance for an open-row hit (1+4+1), and 17 cycles after acceptance for a row miss, which adds T_RP. The bench counts falling edges from the accepting edge and compares the exact count, so a response that is early or late by one cycle fails. A bus model in the bench samples the strobes on falling edges. It records the spacing from the row-strobe fall to the column-strobe fall, the length of each row-low period and each write's strobe ordering, and the bench checks these numbers against R2, R4 and R10.

// File: rtl/edo_ctrl_pkg.sv
`timescale 1ns/1ps
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus precharged, row strobe high
    ST_ROW,    // row strobe low, row address held
    ST_COL,    // column address set up, strobes high
    ST_CAS,    // column strobe(s) low
    ST_CP,     // column precharge, data still held (EDO)
    ST_OPEN,   // row open, waiting for a request
    ST_PRE,    // row precharge
    ST_REF     // bus released to the refresh logic
  } edo_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_wait_timer.sv
`timescale 1ns/1ps
module edo_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_ras_window.sv
`timescale 1ns/1ps
module edo_ras_window #(
  parameter int T_MIN   = 10,
  parameter int T_CLOSE = 1000,
  parameter int W       = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic min_ok,
  output logic close_due
);
  logic [W-1:0] cnt_q;

  // cnt_q holds the number of completed low cycles of the current period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!ras_low)         cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  assign min_ok    = (cnt_q >= W'(T_MIN - 1));
  assign close_due = (cnt_q >= W'(T_CLOSE));
endmodule

// File: rtl/edo_page_tracker.sv
`timescale 1ns/1ps
module edo_page_tracker #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit
);
  logic             valid_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (open_set) begin
      valid_q <= 1'b1;
      row_q   <= open_row;
    end else if (close) begin
      valid_q <= 1'b0;
    end
  end

  assign hit = valid_q && (row_q == probe_row);
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int PIN_W     = 10,
  parameter int DQ_W      = 16,
  parameter int T_RP      = 6,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 2,
  parameter int T_HPC     = 4,
  parameter int T_CAC     = 3,
  parameter int T_AA      = 5,
  parameter int T_RAC     = 10,
  parameter int T_DH      = 2,
  parameter int T_RAS_MIN = 10,
  parameter int T_RAS_MAX = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2*PIN_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DQ_W/8-1:0] req_be,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic [PIN_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_ucas_n,
  output logic              dram_lcas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DQ_W-1:0]   dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_in
);
  localparam int ADDR_W      = 2 * PIN_W;
  localparam int LANES       = DQ_W / 8;
  localparam int CAS_RD_HIT  = imax(imax(T_CAS, T_CAC), T_AA - 1);
  localparam int CAS_RD_MISS = imax(CAS_RD_HIT, T_RAC - T_RCD - 1);
  localparam int CAS_WR      = imax(T_CAS, T_DH);
  localparam int CP_EFF      = imax(T_CP, T_HPC - 1 - CAS_WR);
  localparam int RAS_CLOSE   = T_RAS_MAX - (CAS_RD_MISS + CP_EFF + 3);
  localparam int WAIT_MAX    = imax(imax(T_RP, T_RCD), imax(CAS_RD_MISS, CP_EFF));
  localparam int WAIT_W      = $clog2(WAIT_MAX + 1);
  localparam int RAS_W       = $clog2(T_RAS_MAX + 1);

  edo_state_e state_q, state_d;

  logic [PIN_W-1:0]  row_q, col_q;
  logic              wr_q, first_q, pend_q;
  logic [LANES-1:0]  be_q, be_eff, cas_act;
  logic [DQ_W-1:0]   wd_q, lane_mask, rdata_q;
  logic              rvalid_q;
  logic              accept, timer_load, timer_done;
  logic [WAIT_W-1:0] timer_val;
  logic              ras_low, min_ok, close_due, page_hit;

  // ---------------- request acceptance ----------------
  assign be_eff = (req_be == '0) ? '1 : req_be;

  always_comb begin
    unique case (state_q)
      ST_IDLE: req_ready = !ref_req;
      ST_OPEN: req_ready = !ref_req && !close_due && min_ok;
      default: req_ready = 1'b0;
    endcase
  end

  assign accept = req_valid && req_ready;

  // ---------------- sequencing ----------------
  always_comb begin
    state_d   = state_q;
    timer_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_req) begin
          state_d = ST_REF;
        end else if (accept) begin
          state_d   = ST_ROW;
          timer_val = WAIT_W'(T_RCD - 1);
        end
      end
      ST_ROW: if (timer_done) state_d = ST_COL;
      ST_COL: begin
        state_d = ST_CAS;
        if (wr_q)         timer_val = WAIT_W'(CAS_WR - 1);
        else if (first_q) timer_val = WAIT_W'(CAS_RD_MISS - 1);
        else              timer_val = WAIT_W'(CAS_RD_HIT - 1);
      end
      ST_CAS: begin
        if (timer_done) begin
          state_d   = ST_CP;
          timer_val = WAIT_W'(CP_EFF - 1);
        end
      end
      ST_CP: if (timer_done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (min_ok && (ref_req || close_due)) begin
          state_d   = ST_PRE;
          timer_val = WAIT_W'(T_RP - 1);
        end else if (accept) begin
          if (page_hit) begin
            state_d = ST_COL;
          end else begin
            state_d   = ST_PRE;
            timer_val = WAIT_W'(T_RP - 1);
          end
        end
      end
      ST_PRE: begin
        if (timer_done) begin
          if (pend_q) begin
            state_d   = ST_ROW;
            timer_val = WAIT_W'(T_RCD - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_REF: if (!ref_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign timer_load = (state_d != state_q);

  edo_wait_timer #(.W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (timer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      be_q     <= '0;
      wd_q     <= '0;
      first_q  <= 1'b0;
      pend_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        row_q <= req_addr[ADDR_W-1:PIN_W];
        col_q <= req_addr[PIN_W-1:0];
        wr_q  <= req_write;
        be_q  <= be_eff;
        wd_q  <= req_wdata;
      end
      if (state_d == ST_ROW)     first_q <= 1'b1;
      else if (state_q == ST_CP) first_q <= 1'b0;
      if (state_q == ST_OPEN && accept && !page_hit) pend_q <= 1'b1;
      else if (state_q == ST_PRE && timer_done)      pend_q <= 1'b0;
      rvalid_q <= (state_q == ST_CAS) && timer_done && !wr_q;
      if ((state_q == ST_CAS) && timer_done && !wr_q)
        rdata_q <= dram_dq_in & lane_mask;
    end
  end

  // ---------------- open row and row-strobe window ----------------
  assign ras_low = (state_q == ST_ROW) || (state_q == ST_COL) || (state_q == ST_CAS) ||
                   (state_q == ST_CP)  || (state_q == ST_OPEN);

  edo_page_tracker #(.ROW_W(PIN_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_set  (state_q == ST_ROW),
    .open_row  (row_q),
    .close     (!ras_low),
    .probe_row (req_addr[ADDR_W-1:PIN_W]),
    .hit       (page_hit)
  );

  edo_ras_window #(.T_MIN(T_RAS_MIN), .T_CLOSE(RAS_CLOSE), .W(RAS_W)) u_ras_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_low   (ras_low),
    .min_ok    (min_ok),
    .close_due (close_due)
  );

  // ---------------- byte lanes ----------------
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_act[g]           = (state_q == ST_CAS) && be_q[g];
    assign lane_mask[g*8 +: 8]  = {8{be_q[g]}};
  end

  // ---------------- DRAM pins ----------------
  assign dram_ras_n  = !ras_low;
  assign dram_addr   = ((state_q == ST_COL) || (state_q == ST_CAS) ||
                        (state_q == ST_CP)  || (state_q == ST_OPEN)) ? col_q : row_q;
  assign dram_lcas_n = !cas_act[0];
  assign dram_ucas_n = !cas_act[LANES-1];
  assign dram_we_n   = !(wr_q && ((state_q == ST_COL) || (state_q == ST_CAS)));
  assign dram_oe_n   = !(!wr_q && ((state_q == ST_CAS) || (state_q == ST_CP)));
  assign dram_dq_oe  = wr_q && ((state_q == ST_COL) || (state_q == ST_CAS));
  assign dram_dq_out = wd_q;

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
  assign ref_gnt   = (state_q == ST_REF);
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
`timescale 1ns/1ps
module edo_dram_ctrl_chk #(
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 2,
  parameter int T_RAS_MIN = 10,
  parameter int T_RAS_MAX = 20000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_ready,
  input logic rsp_valid,
  input logic ref_gnt
);
  logic cas_low;
  int   ras_cnt, lo_cnt, hi_cnt;

  assign cas_low = !ucas_n || !lcas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_cnt <= 0;
      lo_cnt  <= 0;
      hi_cnt  <= 0;
    end else begin
      ras_cnt <= ras_n ? 0 : ((ras_cnt <= T_RAS_MAX) ? ras_cnt + 1 : ras_cnt);
      lo_cnt  <= !cas_low ? 0 : ((lo_cnt < 1000) ? lo_cnt + 1 : lo_cnt);
      hi_cnt  <= cas_low ? 0 : ((hi_cnt < 1000) ? hi_cnt + 1 : hi_cnt);
    end
  end

  assert_col_after_rcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_low) && ras_cnt <= T_RCD + 1 + 8) |-> (ras_cnt >= T_RCD + 1));

  assert_cas_low_min_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_low) |-> (lo_cnt >= T_CAS));

  assert_cas_precharge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_low) |-> (hi_cnt >= T_CP));

  assert_ras_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (ras_cnt < T_RAS_MAX));

  assert_ras_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_cnt >= T_RAS_MIN));

  assert_write_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_low && !we_n) |-> (oe_n && dq_oe));

  assert_write_we_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_low) && !we_n) |-> $past(!we_n));

  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cas_low && we_n));

  assert_gnt_ras_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n && !req_ready));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
  .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (dram_ras_n),
  .ucas_n    (dram_ucas_n),
  .lcas_n    (dram_lcas_n),
  .we_n      (dram_we_n),
  .oe_n      (dram_oe_n),
  .dq_oe     (dram_dq_oe),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ref_gnt   (ref_gnt)
);

// File: tb/tb_edo_dram_ctrl.sv
`timescale 1ns/1ps
module tb_edo_dram_ctrl;
  localparam int T_RP = 6, T_RCD = 3, T_RAS_MAX = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, ref_gnt;
  logic [15:0] rsp_rdata, dram_dq_out;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dq_in_r = '0;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  edo_dram_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_r)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- DRAM bus model, sampled on falling edges ----------------
  logic [15:0] mem [256];
  logic [9:0]  row_m;
  bit prev_ras = 1, prev_u = 1, prev_l = 1, prev_we = 1, first_cas = 0;
  int rcnt = 0, last_low = 0, ras_falls = 0, gap_bad = 0, ew_bad = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'hA500 + 16'(i);

  always @(negedge clk) begin
    bit lf, uf;
    int idx;
    if (rst_n) begin
      if (!dram_ras_n) begin
        if (prev_ras) begin
          row_m = dram_addr; ras_falls++; rcnt = 0; first_cas = 1;
        end
        rcnt++;
      end else if (!prev_ras) begin
        last_low = rcnt; rcnt = 0;
      end
      lf = prev_l && !dram_lcas_n;
      uf = prev_u && !dram_ucas_n;
      if (lf || uf) begin
        idx = {row_m[3:0], dram_addr[3:0]};
        if (first_cas) begin
          if (rcnt - 1 != T_RCD + 1) gap_bad++;
          first_cas = 0;
        end
        if (!dram_we_n) begin
          if (prev_we || !dram_oe_n || !dram_dq_oe) ew_bad++;
          if (lf) mem[idx][7:0]  = dram_dq_out[7:0];
          if (uf) mem[idx][15:8] = dram_dq_out[15:8];
        end
        dq_in_r = mem[idx];
      end
      prev_ras = dram_ras_n; prev_u = dram_ucas_n; prev_l = dram_lcas_n; prev_we = dram_we_n;
    end
  end

  // ---------------- request helpers ----------------
  task automatic issue(input bit w, input logic [1:0] be, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_be = be; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic wait_rsp(output int lat, output logic [15:0] data);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 200);
    data = rsp_rdata;
  endtask

  // {write, be, addr, wdata, expected data, expected latency (0 = none)}
  localparam logic [62:0] VEC [12] = '{
    {1'b1, 2'b11, 20'h00412, 16'hBEEF, 16'h0000, 8'd0},   // R1 opens row 1
    {1'b0, 2'b11, 20'h00412, 16'h0000, 16'hBEEF, 8'd6},   // R6 hit
    {1'b1, 2'b01, 20'h00412, 16'h1234, 16'h0000, 8'd0},   // R3 low byte
    {1'b0, 2'b11, 20'h00412, 16'h0000, 16'hBE34, 8'd6},
    {1'b1, 2'b10, 20'h00412, 16'h5600, 16'h0000, 8'd0},   // R3 high byte
    {1'b0, 2'b10, 20'h00412, 16'h0000, 16'h5600, 8'd6},   // R5 masked lane
    {1'b0, 2'b01, 20'h00412, 16'h0000, 16'h0034, 8'd6},
    {1'b0, 2'b00, 20'h00412, 16'h0000, 16'h5634, 8'd6},   // R3 no enables = word
    {1'b0, 2'b11, 20'h00C21, 16'h0000, 16'hA531, 8'd17},  // R7 miss
    {1'b1, 2'b11, 20'h00C21, 16'h0F0F, 16'h0000, 8'd0},
    {1'b0, 2'b11, 20'h00C21, 16'h0000, 16'h0F0F, 8'd6},
    {1'b0, 2'b11, 20'h00C22, 16'h0000, 16'hA532, 8'd6}
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat, cnt;
    logic [15:0] d;
    repeat (5) @(negedge clk);
    // R12 reset state, during reset
    chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n, "R12 strobes in reset",
        {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!dram_dq_oe && !rsp_valid && !ref_gnt, "R12 outputs in reset",
        {dram_dq_oe, rsp_valid, ref_gnt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R12 ready after reset", req_ready, 1);
    chk(dram_ras_n, "R12 row strobe high after reset", dram_ras_n, 1);

    // vector table
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i][62], VEC[i][61:60], VEC[i][59:40], VEC[i][39:24]);
      if (!VEC[i][62]) begin
        wait_rsp(lat, d);
        chk(d == VEC[i][23:8], $sformatf("R5 read data vec %0d", i), d, VEC[i][23:8]);
        chk(lat == int'(VEC[i][7:0]), $sformatf("R5 read latency vec %0d", i), lat, VEC[i][7:0]);
      end
      if (i == 7) chk(ras_falls == 1, "R6 row kept open across hits", ras_falls, 1);
    end
    chk(ras_falls == 2, "R7 miss reopens once", ras_falls, 2);

    // R8: request held while not ready is ignored
    issue(0, 2'b11, 20'h00C22, 16'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!req_ready, "R8 ready low during column cycle", req_ready, 0);
      req_valid = 1; req_write = 1; req_be = 2'b11; req_addr = 20'h00412; req_wdata = 16'hDEAD;
    end
    @(negedge clk); req_valid = 0;
    cnt = 0;
    while (!rsp_valid && cnt < 50) begin @(negedge clk); cnt++; end
    chk(rsp_rdata == 16'hA532, "R8 in-flight read data", rsp_rdata, 16'hA532);
    issue(0, 2'b11, 20'h00412, 16'h0);
    wait_rsp(lat, d);
    chk(d == 16'h5634, "R8 ignored write left memory", d, 16'h5634);
    chk(lat == 17, "R7 miss latency", lat, 17);

    // R9 refresh handshake
    repeat (4) @(negedge clk);
    ref_req = 1;
    #1 chk(!req_ready, "R9 ready drops with refresh request", req_ready, 0);
    cnt = 0;
    while (!ref_gnt && cnt < 100) begin @(negedge clk); cnt++; end
    chk(ref_gnt && dram_ras_n, "R9 grant with row strobe high", {ref_gnt, dram_ras_n}, 3);
    chk(cnt >= T_RP, "R9 grant after precharge", cnt, T_RP);
    repeat (3) @(negedge clk);
    chk(!req_ready, "R9 ready low while granted", req_ready, 0);
    ref_req = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!ref_gnt && req_ready, "R9 grant released", {ref_gnt, req_ready}, 1);
    issue(0, 2'b11, 20'h00C22, 16'h0);
    wait_rsp(lat, d);
    chk(lat == 11 && d == 16'hA532, "R9 row closed by refresh, idle read", lat, 11);

    // R10 idle open row is closed before the limit
    cnt = 0;
    while (!dram_ras_n && cnt < T_RAS_MAX + 100) begin @(negedge clk); cnt++; end
    @(negedge clk);
    chk(last_low < T_RAS_MAX, "R10 row low time under limit", last_low, T_RAS_MAX);
    chk(last_low >= T_RAS_MAX - 20, "R10 row held open while idle", last_low, T_RAS_MAX - 20);

    chk(gap_bad == 0, "R2 row to column spacing", gap_bad, 0);
    chk(ew_bad == 0, "R4 early write ordering", ew_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule